// File: doc/BRIEF.md
# Transmit Statistics Saturating Counter Register

This block keeps four small transmit statistics for a MAC: packets that needed exactly one collision, packets that needed several, packets that were deferred, and packets that hit excessive deferral. The transmit engine reports the outcome of each finished packet on a one-cycle done strobe. That report carries the packet's collision count and two deferral flags. The block updates at most one step per counter for each strobe.

The four counts are packed into one read-only 16-bit word. The counters saturate at 15 and never wrap. Any counter that sits at 15 raises an interrupt request level. A host read, flagged by a one-cycle read strobe, returns the current word and clears all four counts. A packet report that lands in the same cycle as a read is not lost. Software that services transmit completions can therefore keep full statistics just by reading this word, even when no interrupt is raised for successful sends.

Top module: `tx_stat_counters`

## Requirements
- R1: `stat_word` bits 3:0 hold the single-collision count, bits 7:4 the multi-collision count, bits 11:8 the deferred count and bits 15:12 the excessive-deferral count.
- R2: A counter at 15 stays at 15 when another qualifying packet arrives; it never wraps to 0.
- R3: `irq` is high in every cycle in which any counter equals 15, and low otherwise, so it falls in the cycle after a clearing read.
- R4: While `rd_strobe` is high, `stat_word` shows the counts before the read; from the next cycle all counts are 0, unless R11 applies.
- R5: Each counter moves by at most one per cycle in which `pkt_done` is high. Collision count and flags presented while `pkt_done` is low change nothing.
- R6: A packet with `coll_count` equal to 1 adds one to the single-collision count.
- R7: A packet with `coll_count` from 2 to 16 adds one to the multi-collision count. Values 0 and 17 to 31 change neither collision count.
- R8: A packet with `deferred` high adds exactly one to the deferred count, whatever its collision count.
- R9: After a cycle with `rst_n` low at a clock edge, all counts are 0 and `irq` is low.
- R10: A packet with `exc_deferred` high adds one to the excessive-deferral count.
- R11: When `pkt_done` and `rd_strobe` are high in the same cycle, the read returns the counts before that packet. Each counter then restarts at 0 plus that packet's increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pkt_done | input | 1 | One-cycle strobe: a transmit packet has finished |
| coll_count | input | 5 | Collisions seen by the finished packet (0 to 16) |
| deferred | input | 1 | The finished packet was deferred at least once |
| exc_deferred | input | 1 | The finished packet hit excessive deferral |
| rd_strobe | input | 1 | Host read of the statistics word; clears the counts |
| stat_word | output | 16 | Packed counts (layout in R1) |
| irq | output | 1 | Interrupt request level: some counter is at 15 |

## Verification
Assertions check three properties on every cycle. A saturated counter holds its value, a read with no packet leaves a counter at zero, and a counter with neither a read nor an increment keeps its value. A further assertion requires that the interrupt only rises after a packet report. Two properties depend on decoding specific input values and can only be shown by the bench's scenarios. The first is the split of collision counts into single and multiple, including the out-of-range values. The second is the packed bit layout. The bench also covers the read that coincides with a packet report, and the fall of the interrupt after a clearing read.

// File: rtl/tx_stat_pkg.sv
// Shared constants for the transmit statistics register.
// Assumes a 4-bit count per statistic and a 5-bit collision report.
package tx_stat_pkg;
    localparam int NUM_CNT  = 4;
    localparam int CNT_W    = 4;
    localparam int COLL_W   = 5;
    localparam int WORD_W   = NUM_CNT * CNT_W;
    // Counter slots; the slot number sets the nibble position in the word.
    localparam int IDX_SINGLE = 0;
    localparam int IDX_MULTI  = 1;
    localparam int IDX_DEFER  = 2;
    localparam int IDX_EXCDEF = 3;
    // Largest collision count that still classes a packet as multi-collision.
    localparam int MULTI_MAX  = 16;
endpackage

// File: rtl/tx_event_classify.sv
// Turns one packet-done report into one increment request per counter.
// Assumes pkt_done is high for one cycle per finished packet; without it
// no request is raised. Purely combinational.
module tx_event_classify
    import tx_stat_pkg::*;
#(
    parameter int CW   = COLL_W,
    parameter int MMAX = MULTI_MAX
) (
    input  logic          pkt_done,
    input  logic [CW-1:0] coll_count,
    input  logic          deferred,
    input  logic          exc_deferred,
    output logic [NUM_CNT-1:0] inc
);
    localparam logic [CW-1:0] ONE  = CW'(1);
    localparam logic [CW-1:0] TWO  = CW'(2);
    localparam logic [CW-1:0] MTOP = CW'(MMAX);

    // Classify the finished packet into per-counter increment requests.
    always_comb begin
        inc             = '0;
        inc[IDX_SINGLE] = pkt_done && (coll_count == ONE);
        inc[IDX_MULTI]  = pkt_done && (coll_count >= TWO) && (coll_count <= MTOP);
        inc[IDX_DEFER]  = pkt_done && deferred;
        inc[IDX_EXCDEF] = pkt_done && exc_deferred;
    end
endmodule

// File: rtl/stat_sat_counter.sv
// One saturating statistics counter with clear-on-read.
// Assumes clr and inc are single-cycle requests; an increment in the
// same cycle as a clear survives as a count of 1.
module stat_sat_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] cnt,
    output logic         full
);
    localparam logic [W-1:0] MAXV = '1;

    // Count up to the ceiling, restart from zero (plus any event) on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= inc ? W'(1) : '0;
        else if (inc && cnt != MAXV)
            cnt <= cnt + W'(1);
    end

    // Flag the ceiling for the interrupt request.
    always_comb full = (cnt == MAXV);

    // R2: a saturated counter never wraps
    a_r2_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == MAXV && !clr) |=> (cnt == MAXV));
    // R4: a read without an event leaves zero
    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !inc) |=> (cnt == '0));
    // R5: no request, no change
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !inc) |=> $stable(cnt));
endmodule

// File: rtl/tx_stat_counters.sv
// Transmit statistics register: four saturating 4-bit counts packed
// into one read-only word, cleared by a host read, with an interrupt
// level while any count is at its ceiling.
// Assumes rd_strobe marks exactly one host read cycle.
module tx_stat_counters
    import tx_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_done,
    input  logic [COLL_W-1:0] coll_count,
    input  logic              deferred,
    input  logic              exc_deferred,
    input  logic              rd_strobe,
    output logic [WORD_W-1:0] stat_word,
    output logic              irq
);
    logic [NUM_CNT-1:0] inc;
    logic [NUM_CNT-1:0] full;

    tx_event_classify #(.CW(COLL_W), .MMAX(MULTI_MAX)) u_classify (
        .pkt_done     (pkt_done),
        .coll_count   (coll_count),
        .deferred     (deferred),
        .exc_deferred (exc_deferred),
        .inc          (inc)
    );

    // One counter per statistic, each in its own nibble of the word.
    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        stat_sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc[i]),
            .clr   (rd_strobe),
            .cnt   (stat_word[i*CNT_W +: CNT_W]),
            .full  (full[i])
        );
    end

    // Request an interrupt while any counter is saturated.
    always_comb irq = |full;

    // R3: the request can only appear after a packet report
    a_r3_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(pkt_done));
endmodule

// File: tb/tx_stat_counters_bench.sv
module tx_stat_counters_bench;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        pkt_done = 0;
    logic [4:0]  coll_count = 0;
    logic        deferred = 0;
    logic        exc_deferred = 0;
    logic        rd_strobe = 0;
    logic [15:0] stat_word;
    logic        irq;

    int n_chk = 0, n_bad = 0;
    int m_sc = 0, m_mc = 0, m_df = 0, m_xd = 0;
    logic [16:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    tx_stat_counters u_tx_stat_counters (
        .clk(clk), .rst_n(rst_n), .pkt_done(pkt_done), .coll_count(coll_count),
        .deferred(deferred), .exc_deferred(exc_deferred), .rd_strobe(rd_strobe),
        .stat_word(stat_word), .irq(irq)
    );

    function automatic logic [16:0] model_word();
        logic [15:0] w = {4'(m_xd), 4'(m_df), 4'(m_mc), 4'(m_sc)};
        return {(m_sc == 15 || m_mc == 15 || m_df == 15 || m_xd == 15), w};
    endfunction

    function automatic int sat(int v);
        return (v < 15) ? v + 1 : 15;
    endfunction

    task automatic model_pkt(input int c, input bit d, input bit x);
        if (c == 1) m_sc = sat(m_sc);
        if (c >= 2 && c <= 16) m_mc = sat(m_mc);
        if (d) m_df = sat(m_df);
        if (x) m_xd = sat(m_xd);
    endtask

    task automatic check(input string tag, input logic [16:0] act, input logic [16:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual irq=%0b word=%h expected irq=%0b word=%h",
                     tag, act[16], act[15:0], exp[16], exp[15:0]);
        end
    endtask

    // Driver: one packet report, optionally with a read in the same cycle.
    task automatic drive(input bit pk, input int c, input bit d, input bit x,
                         input bit rd, input string tag);
        @(posedge clk); #1;
        pkt_done = pk; coll_count = 5'(c); deferred = d; exc_deferred = x;
        rd_strobe = rd;
        if (rd) begin
            exp_q.push_back(model_word());
            tag_q.push_back(tag);
            m_sc = 0; m_mc = 0; m_df = 0; m_xd = 0;
        end
        if (pk) model_pkt(c, d, x);
        @(posedge clk); #1;
        pkt_done = 0; rd_strobe = 0; coll_count = 0; deferred = 0; exc_deferred = 0;
    endtask

    task automatic pkt(input int c, input bit d, input bit x);
        drive(1, c, d, x, 0, "");
    endtask

    task automatic rd(input string tag);
        drive(0, 0, 0, 0, 1, tag);
    endtask

    // Non-read check of the live word and interrupt between edges.
    task automatic peek(input string tag);
        @(negedge clk);
        check(tag, {irq, stat_word}, model_word());
    endtask

    // Monitor: compare each read result against the queued expectation.
    always @(negedge clk) begin
        if (rd_strobe && exp_q.size() > 0)
            check(tag_q.pop_front(), {irq, stat_word}, exp_q.pop_front());
    end

    initial begin
        #4_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        peek("R9 reset state");
        rd("R9 reset read");
        // R6 single, R7 multi bounds, R1 layout
        pkt(1, 0, 0);
        pkt(2, 0, 0);
        pkt(16, 0, 0);
        pkt(0, 0, 0);
        pkt(17, 0, 0);
        peek("R7 coll 0/17 ignored");
        rd("R1 R6 R7 layout and classes");
        peek("R4 cleared after read");
        // R8 deferred once per packet, R10 excessive deferral
        pkt(5, 1, 0);
        pkt(0, 1, 1);
        rd("R8 R10 deferral counts");
        // R5 inputs without strobe ignored
        @(posedge clk); #1; coll_count = 1; deferred = 1; exc_deferred = 1;
        repeat (3) @(posedge clk);
        #1; coll_count = 0; deferred = 0; exc_deferred = 0;
        peek("R5 no strobe no change");
        // R2 saturation and R3 interrupt
        for (int i = 0; i < 14; i++) pkt(1, 0, 0);
        peek("R3 irq low at 14");
        pkt(1, 0, 0);
        peek("R3 irq high at 15");
        for (int i = 0; i < 4; i++) pkt(1, 1, 0);
        peek("R2 saturated holds");
        rd("R2 R4 read saturated");
        peek("R3 irq drops after read");
        // R11 event coinciding with a read
        pkt(3, 0, 0);
        drive(1, 1, 1, 1, 1, "R11 read returns pre-event");
        peek("R11 event survives clear");
        rd("R11 read of surviving event");
        // R9 reset mid-run
        pkt(1, 1, 1);
        @(posedge clk); #1 rst_n = 0;
        @(posedge clk); #1 rst_n = 1;
        m_sc = 0; m_mc = 0; m_df = 0; m_xd = 0;
        peek("R9 reset clears counts");
        repeat (2) @(posedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule